// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single reservation that a processor core creates with a load-reserved access and uses up with a store-conditional access. While the reservation is armed, the block watches several system bus snoop ports. It looks for writes by any master other than the reserving core that land on the reserved word. When it sees one, it drops the reservation and, on the following clock, raises a one-cycle cancel pulse toward the core.

On the core side the block acts as a gate. A store-conditional reaches the bus only if three things hold: the reservation is still armed, the request addresses the reserved word, and no cancel is being signalled in that cycle. The same cycle carries a single pass/fail status bit back to the core.

Arming and consuming depend only on how the address phase ends, so the block takes no data-phase status. A change to the programmable memory map, signalled by a pulse, also voids the reservation.

Top module: `resv_monitor`

## Requirements
- R1: After reset no reservation is held and `cancel_o` is low, so a store-conditional presented first gets `sc_go` = 0 and `sc_pass` = 0.
- R2: A core access with `core_kind` = 2'b10 (load-reserved) arms the reservation on the 4-byte aligned word that holds `core_addr`, whatever the value of `core_ap_ok`. A later load-reserved replaces the reserved word.
- R3: A core access with `core_kind` = 2'b11 (store-conditional) drives `sc_go` high in the same cycle only when all three of these hold: a reservation is armed, the request is on the reserved word, and `cancel_o` is low. `sc_pass` equals `sc_go` AND `core_ap_ok`.
- R4: A launched store-conditional whose address phase ends normally (`core_ap_ok` = 1) clears the reservation. If the address phase ends in error (`core_ap_ok` = 0), the reservation stays armed.
- R5: A store-conditional that is not launched (no reservation, or a different word) leaves the reservation unchanged.
- R6: A snoop access clears the reservation, on either snoop port, when all of the following hold: `snp_req` = 1, `snp_we` = 1, `snp_ap_ok` = 1, and a master ID different from CORE_ID. The access must also overlap any byte of the reserved word. Its naturally aligned size is 2^`snp_size` bytes (0 = 1 byte, 3 = 8 bytes).
- R7: A snoop access that does not touch the reservation has no effect. This covers reads, writes whose address phase ends in error, writes from CORE_ID, and writes that do not overlap the word.
- R8: `cancel_o` is high for exactly one cycle, the cycle after a snoop touch of an armed reservation or a map change while armed. There is no pulse if a load-reserved is issued in the touch cycle, and that load-reserved then arms the new word.
- R9: A store-conditional presented in a cycle where `cancel_o` is high is rejected.
- R10: A pulse on `map_change` clears the reservation.
- R11: Core accesses with `core_kind` = 2'b00 (read) or 2'b01 (write) do not change the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core access presented this cycle |
| core_kind | input | 2 | Access type: 00 read, 01 write, 10 load-reserved, 11 store-conditional |
| core_addr | input | ADDR_W | Core byte address |
| core_ap_ok | input | 1 | Core address phase ended normally (1) or with error (0) |
| snp_req | input | NUM_SNOOP | Snoop access valid, one bit per port |
| snp_we | input | NUM_SNOOP | Snoop access is a write |
| snp_mid | input | NUM_SNOOP x MID_W | Master ID of the snooped access |
| snp_addr | input | NUM_SNOOP x ADDR_W | Snooped byte address |
| snp_size | input | NUM_SNOOP x 2 | log2 of snooped access size in bytes |
| snp_ap_ok | input | NUM_SNOOP | Snooped address phase ended normally |
| map_change | input | 1 | Programmable memory map was modified |
| cancel_o | output | 1 | One-cycle reservation-lost indication to the core |
| sc_go | output | 1 | Store-conditional may be launched on the bus |
| sc_pass | output | 1 | Store-conditional result: 1 success, 0 fail |

## Verification
The bench builds the block with ADDR_W = 16, MID_W = 4, NUM_SNOOP = 2 and CORE_ID = 3. These settings put both snoop ports in play and let random master IDs often equal the core's own ID. They also confine random addresses to a few neighbouring words, so partial overlaps, 8-byte writes spanning two words and near misses occur often. A nonzero CORE_ID exposes any design that confuses the core's own ID with master zero.

// File: rtl/resv_pkg.sv
// Package: shared access-type encoding for the reservation monitor.
// Assumes the core presents at most one access per cycle.
package resv_pkg;

    typedef enum logic [1:0] {
        ACC_READ      = 2'b00,
        ACC_WRITE     = 2'b01,
        ACC_LOAD_RSV  = 2'b10,
        ACC_STORE_CND = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/resv_snoop_match.sv
// Module: decides whether one snooped access intrudes on the armed reservation.
// Assumes snooped accesses are naturally aligned to 2^size bytes; any byte
// overlap with the reserved granule counts as a touch.
module resv_snoop_match #(
    parameter int ADDR_W   = 32,
    parameter int MID_W    = 4,
    parameter int CORE_ID  = 0,
    parameter int GRAN_LSB = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic                       we,
    input  logic [MID_W-1:0]           mid,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [1:0]                 size,
    input  logic                       ap_ok,
    input  logic                       resv_valid,
    input  logic [ADDR_W-GRAN_LSB-1:0] resv_gran,
    output logic                       hit
);

    localparam logic [MID_W-1:0] OWN_MID = MID_W'(CORE_ID);

    logic [ADDR_W-1:0] cmp_mask;
    logic [ADDR_W-1:0] resv_full;
    logic              overlap;
    logic              foreign_wr;

    // Compare only the bits above the larger of granule and access size.
    always_comb begin
        for (int b = 0; b < ADDR_W; b++) begin
            cmp_mask[b] = (b >= GRAN_LSB) && (b >= int'(size));
        end
    end

    // Overlap test between snooped region and reserved granule.
    always_comb begin
        resv_full = {resv_gran, {GRAN_LSB{1'b0}}};
        overlap   = ((addr ^ resv_full) & cmp_mask) == '0;
    end

    // Qualify: a write by another master with a clean address phase.
    always_comb begin
        foreign_wr = req && we && ap_ok && (mid != OWN_MID);
        hit        = foreign_wr && overlap && resv_valid;
    end

    // R7: reads never count as intrusion.
    a_r7_read_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |-> !hit);

    // R7: the core's own writes never count as intrusion.
    a_r7_own_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (mid == OWN_MID) |-> !hit);

endmodule

// File: rtl/resv_tracker.sv
// Module: holds the reservation valid bit, reserved granule and cancel pulse.
// Assumes at most one of lr_set / sc_clear per cycle; lr_set wins over kills.
module resv_tracker #(
    parameter int GRAN_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_set,
    input  logic [GRAN_W-1:0] set_gran,
    input  logic              touch,
    input  logic              map_change,
    input  logic              sc_clear,
    output logic              valid_q,
    output logic [GRAN_W-1:0] gran_q,
    output logic              cancel_q
);

    // Update reservation state and generate the delayed cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            gran_q   <= '0;
            cancel_q <= 1'b0;
        end else begin
            cancel_q <= (touch || (map_change && valid_q)) && !lr_set;
            if (lr_set) begin
                valid_q <= 1'b1;
                gran_q  <= set_gran;
            end else if (touch || map_change || sc_clear) begin
                valid_q <= 1'b0;
            end
        end
    end

    // R2: a load-reserved always arms the reservation on the next cycle.
    a_r2_lr_arms: assert property (@(posedge clk) disable iff (!rst_n)
        lr_set |=> (valid_q && gran_q == $past(set_gran)));

    // R8: cancel never lasts more than one cycle.
    a_r8_cancel_single: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_q |=> !cancel_q);

    // R10: a map change without a new load-reserved leaves nothing armed.
    a_r10_map_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (map_change && !lr_set) |=> !valid_q);

endmodule

// File: rtl/resv_monitor.sv
// Module: reservation monitor top. Decodes core accesses, gates the
// store-conditional, and merges snoop intrusion from NUM_SNOOP ports.
// Assumes address phase of a core access terminates in its request cycle.
module resv_monitor #(
    parameter int ADDR_W    = 32,
    parameter int MID_W     = 4,
    parameter int NUM_SNOOP = 2,
    parameter int CORE_ID   = 0,
    parameter int GRAN_LSB  = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                core_req,
    input  logic [1:0]                          core_kind,
    input  logic [ADDR_W-1:0]                   core_addr,
    input  logic                                core_ap_ok,
    input  logic [NUM_SNOOP-1:0]                snp_req,
    input  logic [NUM_SNOOP-1:0]                snp_we,
    input  logic [NUM_SNOOP-1:0][MID_W-1:0]     snp_mid,
    input  logic [NUM_SNOOP-1:0][ADDR_W-1:0]    snp_addr,
    input  logic [NUM_SNOOP-1:0][1:0]           snp_size,
    input  logic [NUM_SNOOP-1:0]                snp_ap_ok,
    input  logic                                map_change,
    output logic                                cancel_o,
    output logic                                sc_go,
    output logic                                sc_pass
);
    import resv_pkg::*;

    localparam int GRAN_W = ADDR_W - GRAN_LSB;

    acc_kind_e              kind;
    logic                   lr_set;
    logic                   sc_req;
    logic                   sc_same;
    logic                   resv_valid;
    logic [GRAN_W-1:0]      resv_gran;
    logic [GRAN_W-1:0]      core_gran;
    logic [NUM_SNOOP-1:0]   port_hit;
    logic                   any_hit;

    // Decode the core access type and its granule.
    always_comb begin
        kind      = acc_kind_e'(core_kind);
        core_gran = core_addr[ADDR_W-1:GRAN_LSB];
        lr_set    = core_req && (kind == ACC_LOAD_RSV);
        sc_req    = core_req && (kind == ACC_STORE_CND);
        sc_same   = core_gran == resv_gran;
    end

    // Gate the store-conditional and form its status bit.
    always_comb begin
        sc_go   = sc_req && resv_valid && sc_same && !cancel_o;
        sc_pass = sc_go && core_ap_ok;
    end

    // One intrusion detector per snoop port.
    for (genvar p = 0; p < NUM_SNOOP; p++) begin : g_snoop
        resv_snoop_match #(
            .ADDR_W   (ADDR_W),
            .MID_W    (MID_W),
            .CORE_ID  (CORE_ID),
            .GRAN_LSB (GRAN_LSB)
        ) i_match (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (snp_req[p]),
            .we         (snp_we[p]),
            .mid        (snp_mid[p]),
            .addr       (snp_addr[p]),
            .size       (snp_size[p]),
            .ap_ok      (snp_ap_ok[p]),
            .resv_valid (resv_valid),
            .resv_gran  (resv_gran),
            .hit        (port_hit[p])
        );
    end

    // Any port intruding counts as a touch.
    always_comb any_hit = |port_hit;

    resv_tracker #(
        .GRAN_W (GRAN_W)
    ) i_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_set     (lr_set),
        .set_gran   (core_gran),
        .touch      (any_hit),
        .map_change (map_change),
        .sc_clear   (sc_pass),
        .valid_q    (resv_valid),
        .gran_q     (resv_gran),
        .cancel_q   (cancel_o)
    );

    // R4: a launched store-conditional with clean address phase consumes it.
    a_r4_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |=> !resv_valid);

    // R4: an errored store-conditional keeps the reservation (no touch/map).
    a_r4_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_go && !core_ap_ok && !any_hit && !map_change) |=> resv_valid);

    // R8: a touch without a concurrent load-reserved raises cancel next cycle.
    a_r8_touch_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && !lr_set) |=> cancel_o);

    // R9: nothing is armed while cancel is shown, so no store can launch.
    a_r9_cancel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> !resv_valid);

    // R3: status never reports success without the gate open.
    a_r3_pass_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> sc_go);

endmodule

// File: tb/test_resv_monitor.sv
// Bench: directed corners plus seeded random traffic, checked against a
// behavioural reservation model kept in the bench.
module test_resv_monitor;

    localparam int AW  = 16;
    localparam int MW  = 4;
    localparam int NS  = 2;
    localparam int CID = 3;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    core_req;
    logic [1:0]              core_kind;
    logic [AW-1:0]           core_addr;
    logic                    core_ap_ok;
    logic [NS-1:0]           snp_req;
    logic [NS-1:0]           snp_we;
    logic [NS-1:0][MW-1:0]   snp_mid;
    logic [NS-1:0][AW-1:0]   snp_addr;
    logic [NS-1:0][1:0]      snp_size;
    logic [NS-1:0]           snp_ap_ok;
    logic                    map_change;
    logic                    cancel_o;
    logic                    sc_go;
    logic                    sc_pass;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 0;

    bit            m_valid;
    bit [AW-3:0]   m_gran;
    bit            m_cancel;

    always #4 clk = ~clk;

    resv_monitor #(
        .ADDR_W (AW), .MID_W (MW), .NUM_SNOOP (NS), .CORE_ID (CID), .GRAN_LSB (2)
    ) i_resv_monitor (
        .clk (clk), .rst_n (rst_n),
        .core_req (core_req), .core_kind (core_kind), .core_addr (core_addr),
        .core_ap_ok (core_ap_ok),
        .snp_req (snp_req), .snp_we (snp_we), .snp_mid (snp_mid),
        .snp_addr (snp_addr), .snp_size (snp_size), .snp_ap_ok (snp_ap_ok),
        .map_change (map_change),
        .cancel_o (cancel_o), .sc_go (sc_go), .sc_pass (sc_pass)
    );

    function automatic bit f_touch(input bit [AW-1:0] a, input bit [1:0] s,
                                   input bit [AW-3:0] g);
        if (s <= 2) return (a >> 2) == g;
        return (a >> 3) == (g >> 1);
    endfunction

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        core_req = 0; core_kind = 2'b00; core_addr = '0; core_ap_ok = 1;
        snp_req = '0; snp_we = '0; snp_mid = '0; snp_addr = '0;
        snp_size = '0; snp_ap_ok = '1; map_change = 0;
    endtask

    // Check outputs mid-cycle against the model, then advance the model.
    task automatic apply(input string tag);
        bit exp_go, exp_pass, hit, lr;
        #2;
        exp_go   = core_req && core_kind == 2'b11 && m_valid &&
                   (core_addr >> 2) == m_gran && !m_cancel;
        exp_pass = exp_go && core_ap_ok;
        check(tag, "cancel_o", cancel_o, m_cancel);
        check(tag, "sc_go", sc_go, exp_go);
        check(tag, "sc_pass", sc_pass, exp_pass);
        hit = 0;
        for (int p = 0; p < NS; p++) begin
            if (m_valid && snp_req[p] && snp_we[p] && snp_ap_ok[p] &&
                snp_mid[p] != MW'(CID) && f_touch(snp_addr[p], snp_size[p], m_gran))
                hit = 1;
        end
        lr = core_req && core_kind == 2'b10;
        if (lr) begin
            m_valid = 1; m_gran = core_addr >> 2; m_cancel = 0;
        end else begin
            m_cancel = hit || (map_change && m_valid);
            if (hit || map_change || exp_pass) m_valid = 0;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic core(input bit [1:0] k, input bit [AW-1:0] a, input bit ok, input string tag);
        idle_inputs();
        core_req = 1; core_kind = k; core_addr = a; core_ap_ok = ok;
        apply(tag);
    endtask

    task automatic set_snoop(input int p, input bit [MW-1:0] mid, input bit we,
                             input bit [AW-1:0] a, input bit [1:0] s, input bit ok);
        snp_req[p] = 1; snp_we[p] = we; snp_mid[p] = mid;
        snp_addr[p] = a; snp_size[p] = s; snp_ap_ok[p] = ok;
    endtask

    task automatic snoop(input int p, input bit [MW-1:0] mid, input bit we,
                         input bit [AW-1:0] a, input bit [1:0] s, input bit ok,
                         input string tag);
        idle_inputs();
        set_snoop(p, mid, we, a, s, ok);
        apply(tag);
    endtask

    task automatic idle(input string tag);
        idle_inputs();
        apply(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        bit [AW-1:0] pool [4];
        void'($urandom(32'h5eed_1234));
        pool[0] = 16'h0100; pool[1] = 16'h0104; pool[2] = 16'h0108; pool[3] = 16'h0200;
        idle_inputs();
        rst_n = 0;
        m_valid = 0; m_gran = '0; m_cancel = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        #1;

        // R1: nothing armed out of reset
        core(2'b11, 16'h0100, 1, "R1");
        // R2: load-reserved with errored address phase still arms; R3 pass
        core(2'b10, 16'h0100, 0, "R2");
        core(2'b11, 16'h0102, 1, "R3");
        core(2'b11, 16'h0100, 1, "R4");
        // R4: errored store-conditional keeps the reservation
        core(2'b10, 16'h0200, 1, "R2");
        core(2'b11, 16'h0200, 0, "R4");
        core(2'b11, 16'h0200, 1, "R4");
        // R2: replacement; R5: wrong word leaves state
        core(2'b10, 16'h0104, 1, "R2");
        core(2'b10, 16'h0100, 1, "R2");
        core(2'b11, 16'h0104, 1, "R5");
        core(2'b11, 16'h0100, 1, "R5");
        // R6 port 0 byte write; R8 cancel; R9 store during cancel
        core(2'b10, 16'h0100, 1, "R2");
        snoop(0, 4'd1, 1, 16'h0101, 2'd0, 1, "R6");
        core(2'b11, 16'h0100, 1, "R9");
        idle("R8");
        // R6 port 1 doubleword spanning the word
        core(2'b10, 16'h0104, 1, "R2");
        snoop(1, 4'd2, 1, 16'h0100, 2'd3, 1, "R6");
        idle("R8");
        core(2'b11, 16'h0104, 1, "R6");
        // R7: ignored snoops
        core(2'b10, 16'h0100, 1, "R2");
        snoop(0, 4'd1, 0, 16'h0100, 2'd2, 1, "R7");
        snoop(1, 4'd1, 1, 16'h0100, 2'd2, 0, "R7");
        snoop(0, 4'(CID), 1, 16'h0100, 2'd2, 1, "R7");
        snoop(1, 4'd0, 1, 16'h0104, 2'd2, 1, "R7");
        snoop(0, 4'd5, 1, 16'h0108, 2'd3, 1, "R7");
        core(2'b11, 16'h0100, 1, "R7");
        // R8: touch in the same cycle as a new load-reserved
        core(2'b10, 16'h0100, 1, "R2");
        idle_inputs();
        core_req = 1; core_kind = 2'b10; core_addr = 16'h0200;
        set_snoop(0, 4'd1, 1, 16'h0100, 2'd2, 1);
        apply("R8");
        core(2'b11, 16'h0200, 1, "R8");
        // R10: map change
        core(2'b10, 16'h0100, 1, "R2");
        idle_inputs(); map_change = 1; apply("R10");
        idle("R10");
        core(2'b11, 16'h0100, 1, "R10");
        // R11: plain reads and writes
        core(2'b10, 16'h0100, 1, "R2");
        core(2'b00, 16'h0100, 1, "R11");
        core(2'b01, 16'h0100, 1, "R11");
        core(2'b11, 16'h0100, 1, "R11");

        // Random traffic: R3 R6 R7 R8 R9
        for (int i = 0; i < 4000; i++) begin
            idle_inputs();
            core_req   = ($urandom % 3) != 0;
            core_kind  = 2'($urandom);
            core_addr  = pool[$urandom % 4] | AW'($urandom % 4);
            core_ap_ok = ($urandom % 5) != 0;
            for (int p = 0; p < NS; p++) begin
                snp_req[p]   = ($urandom % 4) == 0;
                snp_we[p]    = ($urandom % 3) != 0;
                snp_mid[p]   = MW'($urandom % 5);
                snp_addr[p]  = pool[$urandom % 4] | AW'($urandom % 8);
                snp_size[p]  = 2'($urandom);
                snp_ap_ok[p] = ($urandom % 4) != 0;
            end
            map_change = ($urandom % 64) == 0;
            apply("R3 R6 R8");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule